// File: doc/BRIEF.md
# Output Impedance Update Sequencer

This block decides when the digital drive-strength code of a set of output drivers is allowed to move. A comparator on the calibration pin reports whether the drivers are currently weaker or stronger than the target, which is one fifth of the external calibration resistor. The block keeps that code as a saturating up/down counter. It only steps the code in cycles where the data drivers are known to be in high impedance, so no transfer on the bus ever sees its drive strength change.

A cycle is an update window when two things are true. The command sampled one cycle earlier must be one that turns the data drivers off: deselect, bank deselect, write or write continue. The per-cycle driver-inactive input must also be high. After reset a settle counter runs for a fixed number of cycles, 8192 by default. The calibration-valid flag rises at the first update window once that count has completed. A stale flag warns when voltage and temperature tracking has gone too long without any window. Reset deassertion is expected to be synchronous to `clk` already.

Top module: `zq_update_seq`

## Requirements
- R1: While `rst_n` is low, `code_o` is mid-scale, (CODE_MIN+CODE_MAX)/2, which is 15 with the defaults. `cal_valid_o` and `stale_o` are both 0.
- R2: `cmd_i` encodings: 0 is deselect, 1 bank deselect, 2 write, 3 write continue, 4 read, 5 read continue. Codes 6 and 7 behave like deselect. Every code other than 4 and 5 makes the following cycle an update window, provided `drv_idle_i` is high in that following cycle.
- R3: A read (4) or read continue (5) command blocks an update in the next cycle, even when `drv_idle_i` is high in that cycle.
- R4: In a cycle with `drv_idle_i` low, `code_o` holds its value.
- R5: At the end of each update window, `code_o` moves up by one when `cmp_up_i` is 1 and down by one when it is 0. The new value is visible after that clock edge.
- R6: `code_o` saturates: it never goes above CODE_MAX (29) or below CODE_MIN (2), whatever `cmp_up_i` asks for.
- R7: `cal_valid_o` stays 0 until SETTLE_CYC clock edges have passed since reset. It then goes to 1 after the first update window and stays 1 until the next reset.
- R8: `stale_o` goes to 1 once STALE_LIMIT (1024) consecutive cycles have passed with no update. It returns to 0 after the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_i | input | 3 | Command sampled each cycle (encoding in R2) |
| drv_idle_i | input | 1 | Data output drivers are in high impedance this cycle |
| cmp_up_i | input | 1 | Comparator result: 1 means strengthen the drivers, 0 means weaken them |
| code_o | output | CODE_W (5) | Drive-strength code |
| cal_valid_o | output | 1 | Impedance counts as settled |
| stale_o | output | 1 | No update for STALE_LIMIT cycles |

## Verification
The code path is tried with several mixes of commands and driver-idle inputs.
- Each deactivating command followed by an idle cycle, which checks that the window opens one cycle after the command.
- Reads and read continues with the idle input high, which separates a window derived from the command from one that trusts the idle input alone.
- Deactivating commands with the idle input low, which shows that the idle input gates the step.

Corner cases are tested separately.
- Long runs in one direction push the code into both limits.
- A read-only stretch crosses the stale limit.
- A window placed just after the settle count completes shows that valid waits for both the count and a window.

// File: rtl/zq_seq_pkg.sv
package zq_seq_pkg;

  typedef enum logic [2:0] {
    ZC_DESEL    = 3'd0,
    ZC_BANK_OFF = 3'd1,
    ZC_WR       = 3'd2,
    ZC_WR_CONT  = 3'd3,
    ZC_RD       = 3'd4,
    ZC_RD_CONT  = 3'd5,
    ZC_SPARE6   = 3'd6,
    ZC_SPARE7   = 3'd7
  } zq_cmd_e;

  // True when the command keeps the data drivers active in the next cycle.
  function automatic logic zq_cmd_drives(input logic [2:0] cmd);
    return (cmd == ZC_RD) || (cmd == ZC_RD_CONT);
  endfunction

endpackage

// File: rtl/zq_window.sv
module zq_window
  import zq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_i,
  input  logic       drv_idle_i,
  output logic       open_o
);

  logic quiet_q;
  logic quiet_d;

  always_comb begin
    quiet_d = !zq_cmd_drives(cmd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quiet_q <= 1'b0;
    else        quiet_q <= quiet_d;
  end

  assign open_o = quiet_q & drv_idle_i;

  // R3: a read-type command keeps the next cycle closed
  a_r3_read_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd4 || cmd_i == 3'd5) |=> !open_o);

  // R4: without the idle indication there is no window
  a_r4_idle_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_idle_i |-> !open_o);

endmodule

// File: rtl/zq_code.sv
module zq_code #(
  parameter int CODE_W   = 5,
  parameter int CODE_MIN = 2,
  parameter int CODE_MAX = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  logic              up_i,
  output logic [CODE_W-1:0] code_o
);

  localparam logic [CODE_W-1:0] CMIN = CODE_W'(CODE_MIN);
  localparam logic [CODE_W-1:0] CMAX = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] CMID = CODE_W'((CODE_MIN + CODE_MAX) / 2);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              code_en;

  always_comb begin
    code_en = 1'b0;
    code_d  = code_q;
    if (upd_i) begin
      if (up_i && code_q < CMAX) begin
        code_en = 1'b1;
        code_d  = code_q + 1'b1;
      end else if (!up_i && code_q > CMIN) begin
        code_en = 1'b1;
        code_d  = code_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= CMID;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

  // R4: code frozen outside update windows
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(code_q));

  // R6: code stays inside its strength limits
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q >= CMIN) && (code_q <= CMAX));

  // R5: a window never moves the code against the comparator
  a_r5_direction: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && up_i) |=> code_q >= $past(code_q));

endmodule

// File: rtl/zq_settle.sv
module zq_settle #(
  parameter int SETTLE_CYC = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  output logic valid_o
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             done;
  logic             valid_q;
  logic             valid_set;

  always_comb begin
    done      = (cnt_q == CNT_END);
    cnt_en    = !done;
    cnt_d     = cnt_q + 1'b1;
    valid_set = done && upd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (valid_set) valid_q <= 1'b1;
  end

  assign valid_o = valid_q;

  // R7: valid only once the settle count has completed
  a_r7_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> done);

  // R7: valid is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);

endmodule

// File: rtl/zq_stale.sv
module zq_stale #(
  parameter int STALE_LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  output logic stale_o
);

  localparam int SW = $clog2(STALE_LIMIT + 1);
  localparam logic [SW-1:0] LIM = SW'(STALE_LIMIT);

  logic [SW-1:0] gap_q;
  logic [SW-1:0] gap_d;
  logic          gap_en;

  always_comb begin
    gap_en = 1'b0;
    gap_d  = gap_q;
    if (upd_i) begin
      gap_en = 1'b1;
      gap_d  = '0;
    end else if (gap_q != LIM) begin
      gap_en = 1'b1;
      gap_d  = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gap_q <= '0;
    else if (gap_en) gap_q <= gap_d;
  end

  assign stale_o = (gap_q == LIM);

  // R8: an update clears the warning
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> !stale_o);

  // R8: the warning persists until an update arrives
  a_r8_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_o && !upd_i) |=> stale_o);

endmodule

// File: rtl/zq_update_seq.sv
module zq_update_seq #(
  parameter int CODE_W      = 5,
  parameter int CODE_MIN    = 2,
  parameter int CODE_MAX    = 29,
  parameter int SETTLE_CYC  = 8192,
  parameter int STALE_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_i,
  input  logic              drv_idle_i,
  input  logic              cmp_up_i,
  output logic [CODE_W-1:0] code_o,
  output logic              cal_valid_o,
  output logic              stale_o
);

  logic upd;

  zq_window u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .drv_idle_i (drv_idle_i),
    .open_o     (upd)
  );

  zq_code #(
    .CODE_W   (CODE_W),
    .CODE_MIN (CODE_MIN),
    .CODE_MAX (CODE_MAX)
  ) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (upd),
    .up_i   (cmp_up_i),
    .code_o (code_o)
  );

  zq_settle #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd),
    .valid_o (cal_valid_o)
  );

  zq_stale #(
    .STALE_LIMIT (STALE_LIMIT)
  ) u_stale (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_i   (upd),
    .stale_o (stale_o)
  );

  // R2: the code can only move in a cycle that follows a non-read command
  a_r2_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 3'd4 || cmd_i == 3'd5) |=> ##1 $stable(code_o));

endmodule

// File: tb/zq_update_seq_bench.sv
module zq_update_seq_bench;

  localparam int CODE_W = 5;
  localparam int CMIN   = 2;
  localparam int CMAX   = 29;
  localparam int SETTLE = 8192;
  localparam int LIMIT  = 1024;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [2:0]        cmd_i;
  logic              drv_idle_i;
  logic              cmp_up_i;
  logic [CODE_W-1:0] code_o;
  logic              cal_valid_o;
  logic              stale_o;

  always #2.5 clk = ~clk;

  zq_update_seq u_zq_update_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_i       (cmd_i),
    .drv_idle_i  (drv_idle_i),
    .cmp_up_i    (cmp_up_i),
    .code_o      (code_o),
    .cal_valid_o (cal_valid_o),
    .stale_o     (stale_o)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // Reference model state, built from the requirements
  int m_code, m_cnt, m_gap;
  bit m_quiet, m_valid;

  // Vector entries: {cmd[2:0], drv_idle, cmp_up}
  localparam logic [4:0] VEC [16] = '{
    {3'd0, 1'b1, 1'b1},  // first cycle after reset: nothing sampled yet
    {3'd0, 1'b1, 1'b1},  // window opened by the previous deselect
    {3'd1, 1'b1, 1'b0},
    {3'd2, 1'b1, 1'b1},
    {3'd3, 1'b1, 1'b1},
    {3'd4, 1'b1, 1'b1},  // write continue opened this cycle
    {3'd5, 1'b1, 1'b1},  // blocked by the read
    {3'd6, 1'b1, 1'b0},  // blocked by the read continue
    {3'd7, 1'b1, 1'b0},
    {3'd0, 1'b0, 1'b1},  // idle input low: hold
    {3'd2, 1'b1, 1'b1},
    {3'd4, 1'b0, 1'b0},
    {3'd1, 1'b1, 1'b0},  // blocked by the read
    {3'd3, 1'b1, 1'b0},
    {3'd5, 1'b1, 1'b1},
    {3'd0, 1'b1, 1'b1}   // blocked by the read continue
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_code  = (CMIN + CMAX) / 2;
    m_cnt   = 0;
    m_gap   = 0;
    m_quiet = 1'b0;
    m_valid = 1'b0;
  endtask

  // Drive one cycle, advance the model, and compare after the edge.
  task automatic step(input logic [2:0] cmd, input logic idle, input logic up,
                      input string tag);
    bit upd;
    @(negedge clk);
    cmd_i      = cmd;
    drv_idle_i = idle;
    cmp_up_i   = up;
    upd = m_quiet && idle;
    if (upd) m_code = up ? ((m_code < CMAX) ? m_code + 1 : m_code)
                         : ((m_code > CMIN) ? m_code - 1 : m_code);
    if (upd && m_cnt == SETTLE) m_valid = 1'b1;
    if (upd) m_gap = 0;
    else if (m_gap < LIMIT) m_gap++;
    if (m_cnt < SETTLE) m_cnt++;
    m_quiet = !(cmd == 3'd4 || cmd == 3'd5);
    @(posedge clk);
    #1;
    check({tag, " code"}, int'(code_o), m_code);
    check({tag, " valid"}, int'(cal_valid_o), int'(m_valid));
    check({tag, " stale"}, int'(stale_o), (m_gap == LIMIT) ? 1 : 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n      = 1'b0;
    cmd_i      = 3'd4;
    drv_idle_i = 1'b0;
    cmp_up_i   = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset code", int'(code_o), 15);
    check("R1 reset valid", int'(cal_valid_o), 0);
    check("R1 reset stale", int'(stale_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R4 R5: vector walk over command and idle mixes
    foreach (VEC[i]) step(VEC[i][4:2], VEC[i][1], VEC[i][0], "R2/R3/R4 vec");

    // R2: write opens the next cycle; code steps up (R5)
    step(3'd2, 1'b0, 1'b1, "R2 write");
    step(3'd4, 1'b1, 1'b1, "R5 step up");
    // R3: read then idle-high cycle must hold
    step(3'd5, 1'b1, 1'b0, "R3 read hold");
    step(3'd0, 1'b1, 1'b0, "R3 rdcont hold");
    // R4: window from command but idle low
    step(3'd0, 1'b0, 1'b0, "R4 idle low");
    step(3'd0, 1'b1, 1'b0, "R5 step down");

    // R6: drive into both limits
    for (int k = 0; k < 20; k++) step(3'd1, 1'b1, 1'b1, "R6 upper");
    check("R6 at max", int'(code_o), CMAX);
    for (int k = 0; k < 32; k++) step(3'd0, 1'b1, 1'b0, "R6 lower");
    check("R6 at min", int'(code_o), CMIN);

    // R8: reads only, no windows, past the stale limit
    for (int k = 0; k < LIMIT + 4; k++) step(3'd4, 1'b1, 1'b1, "R8 no window");
    check("R8 stale set", int'(stale_o), 1);
    check("R7 not valid yet", int'(cal_valid_o), 0);

    // R7: run out the settle count with drivers busy
    while (m_cnt < SETTLE) step(3'd5, 1'b0, 1'b1, "R7 settling");
    check("R7 valid waits window", int'(cal_valid_o), 0);
    step(3'd0, 1'b0, 1'b1, "R7 deselect");
    step(3'd0, 1'b1, 1'b1, "R7 first window");
    check("R7 valid set", int'(cal_valid_o), 1);
    check("R8 stale cleared", int'(stale_o), 0);
    for (int k = 0; k < 8; k++) step(3'd4, 1'b1, 1'b0, "R7 sticky");
    check("R7 still valid", int'(cal_valid_o), 1);

    // R1: reset in mid-run restores the reset state
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 rerun code", int'(code_o), 15);
    check("R1 rerun valid", int'(cal_valid_o), 0);
    check("R1 rerun stale", int'(stale_o), 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step(3'd0, 1'b1, 1'b1, "R1 after reset");

    done = 1'b1;
    finish_run();
  end

endmodule